// File: doc/BRIEF.md
# PHY Control-Register Init Master

This block brings two PHY instances out of reset by programming one control register per lane over each PHY's parallel control port. After a start pulse it raises the port select line of both PHYs. It waits a fixed settling interval, then walks through a built-in list of eight writes: four lanes on the first PHY, then four lanes on the second.

Each write drives a 16-bit address and a 16-bit data word on the target PHY's port together with its write enable. The block then runs a four-phase handshake with the PHY's acknowledge line. Each waiting phase is bounded by a cycle-count timeout. A timeout does not stop the sequence. It sets a sticky error that records the PHY and lane of the first failing write. When the list has been walked, the block signals completion with a single-cycle pulse.

Top module: `phy_cr_init`

## Requirements
- R1: A synchronous active-high reset drives all select, write-enable, address, write-data, busy, done and error outputs to 0.
- R2: A start pulse accepted while idle sets every bit of sel_o to 1 and raises busy_o. sel_o stays 1 until reset. The first write enable rises exactly SETTLE_CYC+1 cycles after busy_o rises, which is 11 cycles at the default of 10.
- R3: Exactly eight writes are issued, in this order: PHY 0 lanes 0,1,2,3, then PHY 1 lanes 0,1,2,3. Each write uses address 0x1008 + 0x100*lane and data 0x0E21, which has bits 0, 5, 9, 10 and 11 set. PHY p uses bits [p*16 +: 16] of addr_o and wdata_o, and both slices are held stable while wen_o[p] is high.
- R4: wen_o[p] is PHY p's write enable, and at most one bit of wen_o is high at a time. The enable falls in the cycle after its acknowledge is seen high. The next enable is raised only after that acknowledge has been seen low, unless a timeout ends the wait.
- R5: If the acknowledge stays low for TMO_CYC cycles, the enable is dropped after exactly TMO_CYC high cycles and the error is set. If the acknowledge stays high for TMO_CYC cycles in the low-wait phase, the block moves on and sets the error. In both cases all eight writes are still issued.
- R6: err_o, err_phy_o and err_lane_o capture the PHY and lane of the first write that timed out. Later timeouts do not change them. They hold until the next accepted start clears them.
- R7: done_o is a one-cycle pulse. It comes in the cycle after the last write's acknowledge is seen low, and busy_o falls in the same cycle.
- R8: A start pulse while busy_o is high is ignored: the write order and count are unchanged and only one done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| ack_i | input | NPHY | Per-PHY acknowledge |
| sel_o | output | NPHY | Per-PHY port select |
| wen_o | output | NPHY | Per-PHY write enable |
| addr_o | output | NPHY*AW | Per-PHY register address, PHY p at [p*AW +: AW] |
| wdata_o | output | NPHY*DW | Per-PHY write data, PHY p at [p*DW +: DW] |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout flag |
| err_phy_o | output | PW | PHY of the first timeout |
| err_lane_o | output | LW | Lane of the first timeout |

## Verification
A corrupted list index shows up at the next rising enable as a wrong PHY bit, a wrong address slice or a wrong write count, so it is caught within one handshake. A timer that counts wrongly changes the number of cycles before the first enable, or the number of high cycles of a timed-out enable, and that is visible in the same run. A handshake state that advances early shows up as an enable rising while the acknowledge is still high, or falling before it. An error register that is overwritten or not cleared shows up at the done pulse of the run concerned.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_ISSUE,
    S_WAIT_HI,
    S_WAIT_LO
  } cr_state_t;
endpackage

// File: rtl/phy_cr_timer.sv
module phy_cr_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phy_cr_list.sv
module phy_cr_list #(
  parameter int          NPHY   = 2,
  parameter int          NLANE  = 4,
  parameter int          AW     = 16,
  parameter int          DW     = 16,
  parameter logic [15:0] BASE   = 16'h1008,
  parameter logic [15:0] STRIDE = 16'h0100,
  parameter logic [15:0] DATA   = 16'h0E21,
  localparam int NW = NPHY * NLANE,
  localparam int IW = (NW < 2) ? 1 : $clog2(NW),
  localparam int PW = (NPHY < 2) ? 1 : $clog2(NPHY),
  localparam int LW = (NLANE < 2) ? 1 : $clog2(NLANE)
) (
  input  logic [IW-1:0] idx,
  output logic [PW-1:0] phy,
  output logic [LW-1:0] lane,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          last
);
  always_comb begin
    int i;
    i    = int'(idx);
    phy  = PW'(i / NLANE);
    lane = LW'(i % NLANE);
    addr = AW'(BASE) + AW'(STRIDE) * AW'(i % NLANE);
    data = DW'(DATA);
    last = (i == NW - 1);
  end
endmodule

// File: rtl/phy_cr_errlog.sv
module phy_cr_errlog #(
  parameter int PW = 1,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  input  logic [PW-1:0] phy_i,
  input  logic [LW-1:0] lane_i,
  output logic          err_o,
  output logic [PW-1:0] phy_o,
  output logic [LW-1:0] lane_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_o  <= 1'b0;
      phy_o  <= '0;
      lane_o <= '0;
    end else if (hit && !err_o) begin
      err_o  <= 1'b1;
      phy_o  <= phy_i;
      lane_o <= lane_i;
    end
  end

  // first failure is kept until a new run clears it
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr) |=> (err_o && $stable(phy_o) && $stable(lane_o)));
endmodule

// File: rtl/phy_cr_init.sv
module phy_cr_init #(
  parameter int          NPHY       = 2,
  parameter int          NLANE      = 4,
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          SETTLE_CYC = 10,
  parameter int          TMO_CYC    = 500000,
  parameter logic [15:0] BASE_ADDR  = 16'h1008,
  parameter logic [15:0] LANE_STEP  = 16'h0100,
  parameter logic [15:0] INIT_DATA  = 16'h0E21,
  localparam int NW = NPHY * NLANE,
  localparam int IW = (NW < 2) ? 1 : $clog2(NW),
  localparam int PW = (NPHY < 2) ? 1 : $clog2(NPHY),
  localparam int LW = (NLANE < 2) ? 1 : $clog2(NLANE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [NPHY-1:0]    ack_i,
  output logic [NPHY-1:0]    sel_o,
  output logic [NPHY-1:0]    wen_o,
  output logic [NPHY*AW-1:0] addr_o,
  output logic [NPHY*DW-1:0] wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [PW-1:0]      err_phy_o,
  output logic [LW-1:0]      err_lane_o
);
  import phy_cr_pkg::*;

  cr_state_t     st;
  logic [IW-1:0] idx;
  logic [PW-1:0] cur_phy;
  logic [LW-1:0] cur_lane;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  logic          cur_last;
  logic          ack_cur;
  logic          settle_exp, tmo_exp;
  logic          hi_exit, lo_exit, tmo_clr, err_hit, accept;

  phy_cr_list #(
    .NPHY(NPHY), .NLANE(NLANE), .AW(AW), .DW(DW),
    .BASE(BASE_ADDR), .STRIDE(LANE_STEP), .DATA(INIT_DATA)
  ) u_list (
    .idx(idx), .phy(cur_phy), .lane(cur_lane),
    .addr(cur_addr), .data(cur_data), .last(cur_last)
  );

  assign ack_cur = ack_i[cur_phy];
  assign accept  = (st == S_IDLE) && start_i;
  assign hi_exit = (st == S_WAIT_HI) && (ack_cur || tmo_exp);
  assign lo_exit = (st == S_WAIT_LO) && (!ack_cur || tmo_exp);
  assign tmo_clr = !((st == S_WAIT_HI) || (st == S_WAIT_LO)) || hi_exit;
  assign err_hit = ((st == S_WAIT_HI) && !ack_cur && tmo_exp) ||
                   ((st == S_WAIT_LO) &&  ack_cur && tmo_exp);

  phy_cr_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .clr(st != S_SETTLE), .expired(settle_exp)
  );

  phy_cr_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst), .clr(tmo_clr), .expired(tmo_exp)
  );

  phy_cr_errlog #(.PW(PW), .LW(LW)) u_err (
    .clk(clk), .rst(rst), .clr(accept), .hit(err_hit),
    .phy_i(cur_phy), .lane_i(cur_lane),
    .err_o(err_o), .phy_o(err_phy_o), .lane_o(err_lane_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      idx    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sel_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_SETTLE;
          busy_o <= 1'b1;
          sel_o  <= '1;
          idx    <= '0;
        end
        S_SETTLE:  if (settle_exp) st <= S_ISSUE;
        S_ISSUE:   st <= S_WAIT_HI;
        S_WAIT_HI: if (hi_exit) st <= S_WAIT_LO;
        S_WAIT_LO: if (lo_exit) begin
          if (cur_last) begin
            st     <= S_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPHY; p++) begin : g_port
    logic mine;
    assign mine = (cur_phy == PW'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        wen_o[p]              <= 1'b0;
        addr_o[p*AW +: AW]    <= '0;
        wdata_o[p*DW +: DW]   <= '0;
      end else if (st == S_ISSUE && mine) begin
        wen_o[p]              <= 1'b1;
        addr_o[p*AW +: AW]    <= cur_addr;
        wdata_o[p*DW +: DW]   <= cur_data;
      end else if (hi_exit && mine) begin
        wen_o[p]              <= 1'b0;
      end
    end
  end

  assert_wen_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wen_o));

  assert_port_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (|(wen_o & $past(wen_o))) |-> ($stable(addr_o) && $stable(wdata_o)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  assert_settle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (wen_o == '0));
endmodule

// File: tb/test_phy_cr_init.sv
`timescale 1ns/1ps
module test_phy_cr_init;
  localparam int NPHY = 2, NLANE = 4, AW = 16, DW = 16;
  localparam int SETTLE = 10, TMO = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NPHY-1:0] ack = '0;
  logic [NPHY-1:0] sel, wen;
  logic [NPHY*AW-1:0] addr;
  logic [NPHY*DW-1:0] wdata;
  logic busy, done, err;
  logic [0:0] err_phy;
  logic [1:0] err_lane;

  int checks = 0, errors = 0;
  bit finished = 0;

  // responder config: mode 0 normal, 1 never acks, 2 ack stuck high
  int mode [NPHY];
  int lat  [NPHY];
  int rcnt [NPHY];

  // monitor state
  int  wr_cnt = 0, settle_cnt = 0, done_cnt = 0, hi_len [NPHY];
  bit  first_wen = 0, done_seen = 0, prev_done = 0;
  logic [NPHY-1:0] prev_wen = '0;
  logic [NPHY*AW-1:0] prev_addr = '0;
  logic [NPHY*DW-1:0] prev_wdata = '0;

  always #2 clk = ~clk;

  phy_cr_init #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) i_phy_cr_init (
    .clk(clk), .rst(rst), .start_i(start), .ack_i(ack),
    .sel_o(sel), .wen_o(wen), .addr_o(addr), .wdata_o(wdata),
    .busy_o(busy), .done_o(done), .err_o(err),
    .err_phy_o(err_phy), .err_lane_o(err_lane)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int w);
    return 32'h1008 + 32'h100 * (w % NLANE);
  endfunction

  // behavioural acknowledge responder
  always @(negedge clk) begin
    for (int p = 0; p < NPHY; p++) begin
      if (wen[p] != ack[p]) begin
        bit allow;
        allow = wen[p] ? (mode[p] != 1) : (mode[p] != 2);
        if (allow && rcnt[p] >= lat[p]) begin
          ack[p]  <= wen[p];
          rcnt[p] <= 0;
        end else rcnt[p] <= rcnt[p] + 1;
      end else rcnt[p] <= 0;
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (start && !busy) begin
        wr_cnt = 0; settle_cnt = 0; first_wen = 0; done_seen = 0; done_cnt = 0;
      end else begin
        if (busy && !first_wen && wen == '0) settle_cnt++;
        for (int p = 0; p < NPHY; p++) begin
          if (wen[p] && !prev_wen[p]) begin
            if (!first_wen) begin
              first_wen = 1;
              chk(settle_cnt == SETTLE + 1, "R2 settle gap", settle_cnt, SETTLE + 1);
            end
            chk(p == wr_cnt / NLANE, "R3 phy order", p, wr_cnt / NLANE);
            chk(addr[p*AW +: AW] == exp_addr(wr_cnt), "R3 address",
                int'(addr[p*AW +: AW]), exp_addr(wr_cnt));
            chk(wdata[p*DW +: DW] == 16'h0E21, "R3 data", int'(wdata[p*DW +: DW]), 32'h0E21);
            if (mode[p] == 0) chk(ack[p] == 1'b0, "R4 ack low before enable", int'(ack[p]), 0);
            wr_cnt++;
            hi_len[p] = 0;
          end
          if (wen[p]) begin
            hi_len[p]++;
            if (prev_wen[p])
              chk(addr[p*AW +: AW] == prev_addr[p*AW +: AW] &&
                  wdata[p*DW +: DW] == prev_wdata[p*DW +: DW], "R3 stable", 0, 0);
          end
          if (!wen[p] && prev_wen[p]) begin
            if (mode[p] == 0) chk(ack[p] == 1'b1, "R4 ack high before drop", int'(ack[p]), 1);
            if (mode[p] == 1) chk(hi_len[p] == TMO, "R5 enable timeout length", hi_len[p], TMO);
          end
        end
        chk($countones(wen) <= 1, "R4 one enable", int'(wen), 0);
        if (done) begin
          done_seen = 1; done_cnt++;
          chk(!busy, "R7 busy low at done", int'(busy), 0);
          chk(wr_cnt == NPHY * NLANE, "R7 done after last write", wr_cnt, NPHY * NLANE);
          if (mode[NPHY-1] == 0) chk(ack[NPHY-1] == 1'b0, "R7 done after ack low", int'(ack[NPHY-1]), 0);
        end
        if (prev_done) chk(!done, "R7 one-cycle done", int'(done), 0);
      end
    end
    prev_done  = done;
    prev_wen   = wen;
    prev_addr  = addr;
    prev_wdata = wdata;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_seq(input int m0, input int m1, input int l0, input int l1,
                         input bit restart, input string tag);
    int guard;
    int ep;
    bit ee;
    mode[0] = m0; mode[1] = m1; lat[0] = l0; lat[1] = l1;
    pulse_start();
    if (restart) begin
      repeat (30) @(posedge clk);
      pulse_start();
    end
    guard = 0;
    while (!done_seen && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_seen, {tag, " R7 done reached"}, int'(done_seen), 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R8 single done"}, done_cnt, 1);
    chk(wr_cnt == 8, {tag, " R5 all writes issued"}, wr_cnt, 8);
    chk(sel == 2'b11, {tag, " R2 select held"}, int'(sel), 3);
    ee = (m0 != 0) || (m1 != 0);
    ep = (m0 != 0) ? 0 : 1;
    chk(err == ee, {tag, " R6 error flag"}, int'(err), int'(ee));
    if (ee) begin
      chk(err_phy == ep[0], {tag, " R6 error phy"}, int'(err_phy), ep);
      chk(err_lane == 2'd0, {tag, " R6 error lane"}, int'(err_lane), 0);
    end
    // let a stuck acknowledge recover before the next run
    mode[0] = 0; mode[1] = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NPHY; p++) begin mode[p] = 0; lat[p] = 0; rcnt[p] = 0; hi_len[p] = 0; end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(sel == '0 && wen == '0, "R1 reset select/enable", int'({sel, wen}), 0);
    chk(addr == '0 && wdata == '0, "R1 reset address/data", int'(addr[15:0]), 0);
    chk(!busy && !done && !err, "R1 reset status", int'({busy, done, err}), 0);

    run_seq(0, 0, 0, 0, 0, "zero latency");
    run_seq(0, 1, 2, 0, 0, "phy1 no ack");
    run_seq(0, 0, 3, 1, 0, "clear after error");
    run_seq(2, 0, 1, 2, 0, "phy0 ack stuck");
    run_seq(1, 1, 0, 0, 0, "both no ack first kept");
    run_seq(0, 0, 4, 3, 1, "restart while busy");
    for (int r = 0; r < 6; r++)
      run_seq(0, 0, int'($urandom_range(0, 8)), int'($urandom_range(0, 8)), 0, "random latency");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule